// File: doc/BRIEF.md
# Ternary Arithmetic Shift Unit

This block holds a word of base-3 digits (trits) in a clocked register and moves it one trit position per cycle. A shift toward the top multiplies the value by three, and a shift toward the bottom divides it by three. Each trit is kept as a two-bit binary code. A mode input chooses how those codes are read: either the unsigned-digit form with digits 0, 1 and 2 and a 3's-complement sign, or the balanced form with digits -1, 0 and +1.

A parallel load writes a whole word. A direction input picks the shift sense. On a left shift, the trit that leaves the top of the word is caught in a one-trit overflow cell, and a flag reports whether that trit carried value the word could not keep. A second flag reports any digit code that is not legal in the selected mode.

Top module: `tern_shift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `q`, `ovf_trit`, `ovf_flag` and `err_flag` are all cleared to zero.
- R2: When `load_en` is high, `q` takes `load_data` at the edge. This holds even if `shift_en` is also high, and the load also clears `ovf_trit` and `ovf_flag`.
- R3: When neither `load_en` nor `shift_en` is high, `q`, `ovf_trit` and `ovf_flag` keep their values.
- R4: A right shift (`shift_en` high, `shift_left` low) drops trit 0. Every other trit moves one place down, so trit i+1 goes to trit i.
- R5: In conventional mode (`mode_bal` low, digit codes 00=0, 01=1, 10=2), a right shift fills the top trit with 2 when the old top trit was 2. Otherwise it fills with 0. The result is floor(value/3), so 2120 becomes 2212.
- R6: In balanced mode (`mode_bal` high, codes 00=0, 01=+1, 11=-1), a right shift always fills the top trit with 0.
- R7: A left shift (`shift_en` and `shift_left` high) moves trit i to trit i+1 and puts code 00 into trit 0.
- R8: On a conventional left shift, `ovf_trit` becomes 00 when the old top pair (top trit first) is 00, 01 or 22. For any other pair, it becomes the old top trit.
- R9: On a balanced left shift, `ovf_trit` always becomes the old top trit.
- R10: `ovf_flag` becomes 1 after a left shift exactly when the new `ovf_trit` is nonzero. A load or a right shift clears it, and it is held while idle.
- R11: `err_flag` is registered every cycle. It is 1 when the new value of `q` contains a code that is illegal in the mode sampled at that edge: 11 in conventional mode, 10 in balanced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load strobe, wins over shift |
| load_data | input | 2*NTRITS | Word to load, trit i at bits 2i+1:2i |
| shift_en | input | 1 | Shift one trit this cycle |
| shift_left | input | 1 | 1 = left (times three), 0 = right (divide by three) |
| mode_bal | input | 1 | 1 = balanced digits, 0 = conventional digits |
| q | output | 2*NTRITS | Registered word |
| ovf_trit | output | 2 | Trit caught on the last saving left shift |
| ovf_flag | output | 1 | Caught trit is nonzero |
| err_flag | output | 1 | Illegal digit code present in `q` |

## Verification
Conventional right shifts are tried on words with a top trit of 2 and with a top trit of 1. This separates the sign-filled floor result from a zero fill. Conventional left shifts cover the top pairs 01, 22, 21, 10 and 02, which separates the pairs that discard the top trit from the pairs that save it, including a saved zero that must leave the flag low. Balanced shifts use positive and negative top trits in both directions to show that the fill stays zero and the top trit is always caught. Directed cases cover load against shift priority, idle hold, flag clearing, and a mode change that makes a stored code illegal.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TC_ZERO = 2'b00;
  localparam trit_t TC_ONE  = 2'b01;
  localparam trit_t TC_TWO  = 2'b10;
  localparam trit_t TB_NEG  = 2'b11;

  // Code that has no meaning in the selected digit set.
  function automatic logic trit_bad(input trit_t t, input logic bal);
    return bal ? (t == 2'b10) : (t == 2'b11);
  endfunction

endpackage

// File: rtl/tern_fill_sel.sv
module tern_fill_sel
  import tern_pkg::*;
(
  input  trit_t top,
  input  logic  bal,
  output trit_t fill
);
  // Balanced words carry sign in the top nonzero trit: fill zero.
  // Conventional words extend a negative sign digit (2).
  always_comb begin
    if (bal)                fill = TC_ZERO;
    else if (top == TC_TWO) fill = TC_TWO;
    else                    fill = TC_ZERO;
  end
endmodule

// File: rtl/tern_legal_scan.sv
module tern_legal_scan
  import tern_pkg::*;
#(
  parameter int NTRITS = 8
) (
  input  logic [2*NTRITS-1:0] vec,
  input  logic                bal,
  output logic                bad
);
  logic [NTRITS-1:0] bad_bits;

  for (genvar i = 0; i < NTRITS; i++) begin : g_trit
    assign bad_bits[i] = trit_bad(vec[2*i+1:2*i], bal);
  end

  assign bad = |bad_bits;
endmodule

// File: rtl/tern_ovf_ctl.sv
module tern_ovf_ctl
  import tern_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ld_clr,
  input  logic  flag_clr,
  input  logic  save_en,
  input  logic  bal,
  input  trit_t top,
  input  trit_t second,
  output trit_t ovf_trit,
  output logic  ovf_flag
);
  trit_t caught;
  logic  sign_only;

  // Conventional pairs whose top trit is pure sign extension.
  always_comb begin
    sign_only = ((top == TC_ZERO) && ((second == TC_ZERO) || (second == TC_ONE))) ||
                ((top == TC_TWO) && (second == TC_TWO));
    if (bal)            caught = top;
    else if (sign_only) caught = TC_ZERO;
    else                caught = top;
  end

  always_ff @(posedge clk) begin
    if (rst || ld_clr) begin
      ovf_trit <= TC_ZERO;
      ovf_flag <= 1'b0;
    end else if (save_en) begin
      ovf_trit <= caught;
      ovf_flag <= (caught != TC_ZERO);
    end else if (flag_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  p_bal_save_r9: assert property (@(posedge clk) disable iff (rst)
    (save_en && bal) |=> (ovf_trit == $past(top)));

  p_conv_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (save_en && !bal && top == TC_TWO && second == TC_TWO) |=> (ovf_trit == TC_ZERO));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (ovf_trit != TC_ZERO));

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !save_en) |=> !ovf_flag);
endmodule

// File: rtl/tern_shift_unit.sv
module tern_shift_unit
  import tern_pkg::*;
#(
  parameter int NTRITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [2*NTRITS-1:0] load_data,
  input  logic                shift_en,
  input  logic                shift_left,
  input  logic                mode_bal,
  output logic [2*NTRITS-1:0] q,
  output logic [1:0]          ovf_trit,
  output logic                ovf_flag,
  output logic                err_flag
);
  localparam int W = 2 * NTRITS;

  logic         do_shift;
  logic [W-1:0] q_next;
  trit_t        fill;
  logic         bad_next;

  assign do_shift = shift_en & ~load_en;

  tern_fill_sel u_fill (
    .top  (q[W-1:W-2]),
    .bal  (mode_bal),
    .fill (fill)
  );

  always_comb begin
    if (load_en)         q_next = load_data;
    else if (!shift_en)  q_next = q;
    else if (shift_left) q_next = {q[W-3:0], TC_ZERO};
    else                 q_next = {fill, q[W-1:2]};
  end

  tern_legal_scan #(.NTRITS(NTRITS)) u_scan (
    .vec (q_next),
    .bal (mode_bal),
    .bad (bad_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      err_flag <= 1'b0;
    end else begin
      q        <= q_next;
      err_flag <= bad_next;
    end
  end

  tern_ovf_ctl u_ovf (
    .clk      (clk),
    .rst      (rst),
    .ld_clr   (load_en),
    .flag_clr (do_shift & ~shift_left),
    .save_en  (do_shift & shift_left),
    .bal      (mode_bal),
    .top      (q[W-1:W-2]),
    .second   (q[W-3:W-4]),
    .ovf_trit (ovf_trit),
    .ovf_flag (ovf_flag)
  );

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(load_data)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> (q == $past(q)));

  p_rsh_move_r4: assert property (@(posedge clk) disable iff (rst)
    (do_shift && !shift_left) |=> (q[W-3:0] == $past(q[W-1:2])));

  p_conv_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (do_shift && !shift_left && !mode_bal && q[W-1:W-2] == TC_TWO) |=> (q[W-1:W-2] == TC_TWO));

  p_bal_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (do_shift && !shift_left && mode_bal) |=> (q[W-1:W-2] == TC_ZERO));

  p_lsh_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (do_shift && shift_left) |=> (q[1:0] == TC_ZERO && q[W-1:2] == $past(q[W-3:0])));
endmodule

// File: tb/tern_shift_unit_tb_top.sv
module tern_shift_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         shift_en = 1'b0;
  logic         shift_left = 1'b0;
  logic         mode_bal = 1'b0;
  logic [W-1:0] q;
  logic [1:0]   ovf_trit;
  logic         ovf_flag;
  logic         err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tern_shift_unit #(.NTRITS(N)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .shift_en(shift_en), .shift_left(shift_left), .mode_bal(mode_bal),
    .q(q), .ovf_trit(ovf_trit), .ovf_flag(ovf_flag), .err_flag(err_flag)
  );

  // {mode_bal, shift_left, load word, expected q, expected ovf_trit, expected flag, expected err}
  localparam logic [21:0] VECS [0:13] = '{
    {1'b0, 1'b0, 8'b10011000, 8'b10100110, 2'b00, 1'b0, 1'b0}, // R5 2120 -> 2212
    {1'b0, 1'b0, 8'b01011000, 8'b00010110, 2'b00, 1'b0, 1'b0}, // R5 1120 -> 0112
    {1'b0, 1'b1, 8'b00011001, 8'b01100100, 2'b00, 1'b0, 1'b0}, // R8 pair 01
    {1'b0, 1'b1, 8'b10011001, 8'b01100100, 2'b10, 1'b1, 1'b0}, // R8 pair 21
    {1'b0, 1'b1, 8'b10101001, 8'b10100100, 2'b00, 1'b0, 1'b0}, // R8 pair 22
    {1'b0, 1'b1, 8'b01001001, 8'b00100100, 2'b01, 1'b1, 1'b0}, // R8 pair 10
    {1'b0, 1'b1, 8'b00100101, 8'b10010100, 2'b00, 1'b0, 1'b0}, // R8 pair 02
    {1'b1, 1'b0, 8'b01000101, 8'b00010001, 2'b00, 1'b0, 1'b0}, // R6 +0++
    {1'b1, 1'b0, 8'b11000101, 8'b00110001, 2'b00, 1'b0, 1'b0}, // R6 -0++
    {1'b1, 1'b1, 8'b01000100, 8'b00010000, 2'b01, 1'b1, 1'b0}, // R9 top +
    {1'b1, 1'b1, 8'b00110111, 8'b11011100, 2'b00, 1'b0, 1'b0}, // R9 top 0
    {1'b1, 1'b1, 8'b11010000, 8'b01000000, 2'b11, 1'b1, 1'b0}, // R9 top -
    {1'b0, 1'b0, 8'b00001100, 8'b00000011, 2'b00, 1'b0, 1'b1}, // R11 conv code 11
    {1'b1, 1'b0, 8'b00100000, 8'b00001000, 2'b00, 1'b0, 1'b1}  // R11 bal code 10
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] d, input logic bal);
    load_en = 1'b1; load_data = d; mode_bal = bal; shift_en = 1'b0;
    tick();
    load_en = 1'b0;
  endtask

  task automatic do_shift(input logic left);
    shift_en = 1'b1; shift_left = left;
    tick();
    shift_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    tick();
    chk("R1", "q after reset", q, 0);
    chk("R1", "ovf_trit after reset", ovf_trit, 0);
    chk("R1", "flags after reset", {ovf_flag, err_flag}, 0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      logic [21:0] v;
      string tag;
      v = VECS[i];
      tag = v[20] ? (v[21] ? "R9" : "R8") : (v[21] ? "R6" : "R5");
      if (v[0]) tag = "R11";
      do_load(v[19:12], v[21]);
      do_shift(v[20]);
      chk(tag, $sformatf("q vec %0d", i), q, v[11:4]);
      chk(v[20] ? "R7" : "R4", $sformatf("shift move vec %0d", i), q, v[11:4]);
      chk(tag, $sformatf("ovf_trit vec %0d", i), ovf_trit, v[3:2]);
      chk("R10", $sformatf("ovf_flag vec %0d", i), ovf_flag, v[1]);
      chk("R11", $sformatf("err_flag vec %0d", i), err_flag, v[0]);
    end

    // R3: hold after a flagged left shift (conv 2121 -> 1210, ovf 2)
    do_load(8'b10011001, 1'b0);
    do_shift(1'b1);
    tick(); tick();
    chk("R3", "q held", q, 8'b01100100);
    chk("R3", "ovf_trit held", ovf_trit, 2'b10);
    chk("R10", "flag held idle", ovf_flag, 1'b1);

    // R10: right shift clears flag, keeps trit
    do_shift(1'b0);
    chk("R10", "flag cleared by right shift", ovf_flag, 1'b0);
    chk("R4", "right shift of 1210", q, 8'b00011001);
    chk("R10", "trit kept by right shift", ovf_trit, 2'b10);

    // R2: load wins when shift also requested
    shift_en = 1'b1; shift_left = 1'b1; load_en = 1'b1; load_data = 8'b01010101; mode_bal = 1'b0;
    tick();
    load_en = 1'b0; shift_en = 1'b0;
    chk("R2", "load beats shift", q, 8'b01010101);
    chk("R2", "load clears ovf_trit", ovf_trit, 2'b00);

    // R2: load clears a set flag
    do_load(8'b01001001, 1'b0);
    do_shift(1'b1);
    chk("R10", "flag set pair 10", ovf_flag, 1'b1);
    do_load(8'b00000001, 1'b0);
    chk("R2", "load clears ovf_flag", ovf_flag, 1'b0);

    // R11: mode change while idle makes a stored code illegal
    do_load(8'b10000000, 1'b0);
    chk("R11", "code 10 legal in conv", err_flag, 1'b0);
    mode_bal = 1'b1;
    tick();
    chk("R11", "code 10 illegal in bal", err_flag, 1'b1);
    mode_bal = 1'b0;
    tick();
    chk("R11", "error clears in conv", err_flag, 1'b0);

    // R5: repeated right shifts of -1 (2222) stay -1
    do_load(8'b10101010, 1'b0);
    do_shift(1'b0);
    do_shift(1'b0);
    chk("R5", "2222 stays 2222", q, 8'b10101010);

    // R1: reset mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1", "reset clears q", q, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule